// File: doc/BRIEF.md
# Power-Failure State Capture Register

This block keeps a record of the power state the system occupied at the moment power was lost. It watches a live 3-bit power-state code and two failure conditions. The first is a strobe that marks entry into mechanical-off. The second is the power-good input dropping while the active-low power-on request is asserted. On the first failure after the record was cleared, it stores the live state. It then keeps that value until software clears the field back to the "no failure" code.

Alongside the record it holds two more bits:
- A boot-behaviour bit that tells the sequencer whether applying auxiliary power leads to full-on (0) or soft-off (1).
- A sticky flag that is set when the always-on domain loses validity.

Software reaches all three through a small byte-wide register port. A reset-command write clears the boot bit. The asynchronous reset `rst_ni` stands for the always-on domain becoming valid and loads every default.

Top module: `pwr_fail_capture`

## Requirements
- R1: After reset the failure field reads 4 (no failure), the boot bit reads 0 and the always-on-lost flag reads 0.
- R2: A cycle with `mech_off_i` high stores the live `pwr_state_i` into the failure field, visible after the next clock edge. The codes are: 0 full on, 1 power-on suspend, 2 C2, 3 C3, 4 no failure, 5 suspend to RAM, 6 suspend to disk, 7 soft off.
- R3: A 1-to-0 transition of `pwr_good_i` stores the live state only while `pwr_on_req_ni` is 0. The field updates three clock edges after the input changes, because of a two-flop synchronizer and an edge flop. With `pwr_on_req_ni` at 1, the same transition leaves the field unchanged.
- R4: Once the field holds a value other than 4, later failure events leave it unchanged until it is cleared.
- R5: Writing the status byte (address 0) with bit 3 set returns the field to 4. Writing bit 3 as 0, or writing any value to bits 2:0, leaves the field unchanged.
- R6: When a failure event and a clear write land in the same cycle, the field takes the live state and does not take 4.
- R7: Status bit 5 is the boot bit. It is read-write and drives `boot_soft_off_o`, where 1 selects soft-off and 0 selects full-on.
- R8: A write to address 1 with bits 2:1 equal to 11b clears the boot bit. Any other value at address 1 leaves it unchanged.
- R9: A 1-to-0 transition of `aon_valid_i` sets the always-on-lost flag (status bit 4) three edges later. Writing 1 to bit 4 clears it, and writing 0 leaves it set.
- R10: One falling edge of `pwr_good_i` is detected once. After a capture and a clear, a `pwr_good_i` that stays low, or later rises, causes no further capture.
- R11: Reading address 0 returns {2'b00, boot bit, lost flag, 1'b0, field[2:0]}. Reading address 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset, always-on domain becoming valid |
| pwr_state_i | input | 3 | Live power-state code |
| mech_off_i | input | 1 | Mechanical-off entry strobe, synchronous |
| pwr_good_i | input | 1 | Power-good, asynchronous |
| pwr_on_req_ni | input | 1 | Power-on request, active low |
| aon_valid_i | input | 1 | Always-on domain valid, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| fail_state_o | output | 3 | Retained failure-state field |
| boot_soft_off_o | output | 1 | Boot-behaviour bit |
| aon_lost_o | output | 1 | Sticky always-on-lost flag |

## Verification
The assertions assume two things about the inputs. `mech_off_i`, `pwr_on_req_ni` and `pwr_state_i` are stable at the capturing edge. `pwr_good_i` and `aon_valid_i` need only be level signals, since they are synchronized before use. The bench changes every input at the falling clock edge. It holds the power-on request and live state steady across the whole synchronizer latency of each power-good test. It issues register writes as single-cycle strobes, so the clear and capture paths see clean one-cycle events except in the deliberate same-cycle collision of R6.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [2:0] {
    PS_FULL_ON  = 3'd0,
    PS_ON_SUSP  = 3'd1,
    PS_C2       = 3'd2,
    PS_C3       = 3'd3,
    PS_NO_FAIL  = 3'd4,
    PS_SUSP_RAM = 3'd5,
    PS_SUSP_DSK = 3'd6,
    PS_SOFT_OFF = 3'd7
  } pstate_e;

  localparam int unsigned STATE_W  = 3;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMD    = 2'd1;

  localparam int unsigned BIT_CLR_FAIL = 3;
  localparam int unsigned BIT_LOST     = 4;
  localparam int unsigned BIT_BOOT     = 5;
  localparam int unsigned BIT_CMD_LO   = 1;
  localparam int unsigned BIT_CMD_HI   = 2;
endpackage

// File: rtl/pfc_fall_det.sv
module pfc_fall_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~sync_q[STAGES-1];

  // a fall pulse lasts exactly one cycle (R10)
  p_single_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/pfc_fail_field.sv
module pfc_fail_field
  import pfc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               event_i,
  input  logic               clr_i,
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] field_o
);
  logic [STATE_W-1:0] field_q;
  logic               armed;

  // a same-cycle clear re-arms, so the capture wins (R6)
  assign armed = (field_q == PS_NO_FAIL) | clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               field_q <= PS_NO_FAIL;
    else if (event_i && armed) field_q <= state_i;
    else if (clr_i)            field_q <= PS_NO_FAIL;
  end

  assign field_o = field_q;

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && field_o == PS_NO_FAIL) |=> field_o == $past(state_i));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o != PS_NO_FAIL && !clr_i) |=> $stable(field_o));
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !event_i) |=> field_o == PS_NO_FAIL);
  p_capture_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && event_i) |=> field_o == $past(state_i));
endmodule

// File: rtl/pfc_ctrl_bits.sv
module pfc_ctrl_bits (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boot_we_i,
  input  logic boot_d_i,
  input  logic rst_cmd_i,
  input  logic lost_set_i,
  input  logic lost_clr_i,
  output logic boot_o,
  output logic lost_o
);
  logic boot_q, lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        boot_q <= 1'b0;
    else if (rst_cmd_i) boot_q <= 1'b0;
    else if (boot_we_i) boot_q <= boot_d_i;
  end

  // hardware set beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lost_q <= 1'b0;
    else if (lost_set_i) lost_q <= 1'b1;
    else if (lost_clr_i) lost_q <= 1'b0;
  end

  assign boot_o = boot_q;
  assign lost_o = lost_q;

  p_boot_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd_i |=> !boot_o);
  p_lost_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_set_i |=> lost_o);
  p_lost_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && !lost_clr_i) |=> lost_o);
endmodule

// File: rtl/pwr_fail_capture.sv
module pwr_fail_capture
  import pfc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        pwr_state_i,
  input  logic              mech_off_i,
  input  logic              pwr_good_i,
  input  logic              pwr_on_req_ni,
  input  logic              aon_valid_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [2:0]        fail_state_o,
  output logic              boot_soft_off_o,
  output logic              aon_lost_o
);
  logic pg_level, pg_fall, av_level, av_fall;
  logic wr_status, wr_cmd, clr_fail, rst_cmd, fail_evt;

  pfc_fall_det #(.STAGES(2)) u_pg_det (
    .clk_i, .rst_ni, .async_i(pwr_good_i), .level_o(pg_level), .fall_o(pg_fall)
  );

  pfc_fall_det #(.STAGES(2)) u_av_det (
    .clk_i, .rst_ni, .async_i(aon_valid_i), .level_o(av_level), .fall_o(av_fall)
  );

  assign wr_status = wr_en_i && (addr_i == ADDR_STATUS);
  assign wr_cmd    = wr_en_i && (addr_i == ADDR_CMD);
  assign clr_fail  = wr_status && wdata_i[BIT_CLR_FAIL];
  assign rst_cmd   = wr_cmd && (wdata_i[BIT_CMD_HI:BIT_CMD_LO] == 2'b11);
  assign fail_evt  = mech_off_i | (pg_fall & ~pwr_on_req_ni);

  pfc_fail_field u_field (
    .clk_i, .rst_ni,
    .event_i(fail_evt),
    .clr_i(clr_fail),
    .state_i(pwr_state_i),
    .field_o(fail_state_o)
  );

  pfc_ctrl_bits u_ctrl (
    .clk_i, .rst_ni,
    .boot_we_i(wr_status),
    .boot_d_i(wdata_i[BIT_BOOT]),
    .rst_cmd_i(rst_cmd),
    .lost_set_i(av_fall),
    .lost_clr_i(wr_status && wdata_i[BIT_LOST]),
    .boot_o(boot_soft_off_o),
    .lost_o(aon_lost_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_STATUS) begin
      rdata_o[STATE_W-1:0] = fail_state_o;
      rdata_o[BIT_LOST]    = aon_lost_o;
      rdata_o[BIT_BOOT]    = boot_soft_off_o;
    end
  end

  logic unused_lvl;
  assign unused_lvl = pg_level ^ av_level;

  // a power-good fall without a power-on request must not disturb a clear field (R3)
  p_no_req_no_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_state_o == PS_NO_FAIL && !mech_off_i && pwr_on_req_ni && !clr_fail)
      |=> fail_state_o == PS_NO_FAIL);
  p_cmd_no_effect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_status && !rst_cmd) |=> $stable(boot_soft_off_o));
endmodule

// File: tb/pwr_fail_capture_test.sv
`timescale 1ns/1ps
module pwr_fail_capture_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [2:0] state = 0;
  logic       mech = 0, pg = 1, req_n = 1, av = 1, we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [2:0] field;
  logic       boot, lost;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pwr_fail_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_state_i(state), .mech_off_i(mech),
    .pwr_good_i(pg), .pwr_on_req_ni(req_n), .aon_valid_i(av),
    .wr_en_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .fail_state_o(field), .boot_soft_off_o(boot), .aon_lost_o(lost)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1;
    cyc(1);
    we = 0; wdata = 0; addr = 0;
  endtask

  task automatic clear_field();
    wr(2'd0, {2'b00, boot, 5'b01000});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(2);
    rst_n = 1;
    cyc(4);
    chk("R1 field", {5'b0, field}, 8'h04);
    chk("R1 boot", {7'b0, boot}, 8'h00);
    chk("R1 lost", {7'b0, lost}, 8'h00);
    chk("R11 status read", rdata, 8'h04);

    // R2 sweep all codes through mech-off strobe
    for (int s = 0; s < 8; s++) begin
      state = 3'(s);
      mech = 1; cyc(1); mech = 0;
      chk("R2 mech capture", {5'b0, field}, 8'(s));
      clear_field();
      chk("R5 clear", {5'b0, field}, 8'h04);
    end

    // R3 sweep with request asserted
    for (int s = 0; s < 8; s++) begin
      state = 3'(s); req_n = 0;
      pg = 0; cyc(2);
      chk("R3 not yet", {5'b0, field}, 8'h04);
      cyc(1);
      chk("R3 pg capture", {5'b0, field}, 8'(s));
      req_n = 1; pg = 1; cyc(4);
      clear_field();
    end

    // R3 request deasserted
    state = 3'd6; req_n = 1; pg = 0; cyc(5);
    chk("R3 no request", {5'b0, field}, 8'h04);
    pg = 1; cyc(4);

    // R4 hold, R5 ineffective writes
    state = 3'd5; mech = 1; cyc(1); mech = 0;
    state = 3'd2; mech = 1; cyc(1); mech = 0;
    chk("R4 hold mech", {5'b0, field}, 8'h05);
    req_n = 0; pg = 0; cyc(4); req_n = 1; pg = 1; cyc(4);
    chk("R4 hold pg", {5'b0, field}, 8'h05);
    wr(2'd0, 8'h07);
    chk("R5 low bits ignored", {5'b0, field}, 8'h05);
    wr(2'd0, 8'h00);
    chk("R5 zero ignored", {5'b0, field}, 8'h05);

    // R6 capture wins over clear, both when holding and when clear
    state = 3'd3; mech = 1; addr = 0; wdata = 8'h08; we = 1;
    cyc(1); mech = 0; we = 0; wdata = 0;
    chk("R6 collide held", {5'b0, field}, 8'h03);
    clear_field();
    state = 3'd1; mech = 1; addr = 0; wdata = 8'h08; we = 1;
    cyc(1); mech = 0; we = 0; wdata = 0;
    chk("R6 collide clear", {5'b0, field}, 8'h01);
    clear_field();

    // R10 one detect per edge
    state = 3'd7; req_n = 0; pg = 0; cyc(3);
    chk("R10 first", {5'b0, field}, 8'h07);
    clear_field();
    cyc(6);
    chk("R10 stays low", {5'b0, field}, 8'h04);
    pg = 1; cyc(5);
    chk("R10 rise", {5'b0, field}, 8'h04);
    req_n = 1;

    // R7 boot bit
    wr(2'd0, 8'h20);
    chk("R7 boot set", {7'b0, boot}, 8'h01);
    chk("R11 boot read", rdata, 8'h24);
    // R8 command values other than 11b
    for (int v = 0; v < 3; v++) begin
      wr(2'd1, 8'(v << 1));
      chk("R8 no effect", {7'b0, boot}, 8'h01);
    end
    addr = 2'd1; cyc(1);
    chk("R11 cmd read", rdata, 8'h00);
    wr(2'd1, 8'h06);
    chk("R8 cmd clears", {7'b0, boot}, 8'h00);
    wr(2'd0, 8'h20);
    wr(2'd0, 8'h00);
    chk("R7 boot write 0", {7'b0, boot}, 8'h00);

    // R9 sticky flag
    av = 0; cyc(2);
    chk("R9 not yet", {7'b0, lost}, 8'h00);
    cyc(1);
    chk("R9 set", {7'b0, lost}, 8'h01);
    av = 1; cyc(4);
    wr(2'd0, 8'h00);
    chk("R9 write 0", {7'b0, lost}, 8'h01);
    chk("R11 lost read", rdata, 8'h14);
    wr(2'd0, 8'h10);
    chk("R9 w1c", {7'b0, lost}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule